// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Master Mode)

This block sends a stereo pair of 16-bit two's-complement samples out over a three-wire audio serial link, with the block as clock master. From the system master clock it derives a bit clock at 64 times the sample rate. It also produces a frame clock that marks the left and right halves of each 64-bit frame, a word clock that marks where the sample bits sit, and the serial data line.

Each channel occupies a 32-bit field. Two select pins place the 16 sample bits inside that field in one of four ways:
- left-justified;
- the common inter-IC-sound placement, with a one-bit delay;
- right-justified;
- right-justified and shifted one bit later, where the word clock shrinks to a one-bit marker and the LSB spills into the first bit of the following field.

A third select chooses which bit-clock edge launches data. A ratio select sets the bit clock to a quarter or a sixth of the master clock. Every register runs on the master clock and is advanced by clock enables.

A producer writes a sample pair with a one-cycle strobe. The pair is held and enters the serializer at the next frame boundary.

Top module: `stereo_ser_tx`

## Requirements
- R1: The bit clock period is 4 master clocks when `ratio_384` is 0 and 6 when it is 1. The level that follows a launch edge lasts the first half of that period.
- R2: With `edge_fall_tx` = 1, data, word clock and frame clock change only on the falling bit-clock edge, so they are valid on the rising edge. With `edge_fall_tx` = 0 the edges are swapped. `bclk_o` is therefore low after a launch when the select is 1, and high when it is 0.
- R3: A frame is 64 bit clocks. `lrclk_o` is high for the 32-bit left field, then low for the 32-bit right field.
- R4: With {`fmt_right`,`fmt_delay`} = 00, the MSB occupies field bit 0 and the word clock is high for field bits 0..15.
- R5: With {`fmt_right`,`fmt_delay`} = 01, the MSB occupies field bit 1 and the word clock is high for field bits 1..16.
- R6: With {`fmt_right`,`fmt_delay`} = 10, the MSB occupies field bit 16, the LSB occupies bit 31, and the word clock is high for bits 16..31.
- R7: With {`fmt_right`,`fmt_delay`} = 11, the word clock is high only during field bit 16 and the MSB occupies bit 17. The LSB of each word is sent in bit 0 of the next field: the left LSB in right-field bit 0, and the right LSB in left-field bit 0 of the following frame.
- R8: Every field bit that carries no sample bit is driven 0.
- R9: A strobe on `smp_ready` captures both samples. The values held when a frame begins are the ones sent in that frame. A later strobe in the same frame replaces the held pair without touching the frame in flight.
- R10: While `rst_n` is low, `lrclk_o`, `wclk_o` and `sdata_o` are 0 and `bclk_o` sits at its post-launch level (the inverse of `edge_fall_tx`). Held and in-flight samples are cleared, so the first frame after reset carries zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_384 | input | 1 | Master-to-bit-clock ratio: 0 divides by 4, 1 divides by 6 |
| fmt_right | input | 1 | Placement select, upper bit |
| fmt_delay | input | 1 | Placement select, lower bit |
| edge_fall_tx | input | 1 | 1: launch on falling bit-clock edge; 0: launch on rising edge |
| smp_ready | input | 1 | One-cycle strobe that captures both samples |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, high for the left field |
| wclk_o | output | 1 | Word clock marking the sample bits |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The bench covers every combination of placement, launch edge and clock ratio. In each one it sends directed corner words (0x8000, 0x7FFF, 0x0001, 0xFFFE) and then random pairs, comparing every sampled bit and word-clock level against a field model.

The asymmetric corner words expose an off-by-one MSB position, a reversed bit order or a left/right swap, any of which a symmetric value would hide. Odd LSBs make the spilled bit of the delayed right-justified mode visible, so a missing or wrong-channel spill shows up. A double strobe inside one frame separates "last write wins at the frame boundary" from "the write enters the frame in flight".

// File: rtl/stx_pkg.sv
// Shared types for the stereo serial transmitter.
// Assumes the placement code is formed as {right-justify, delay}.
package stx_pkg;

    typedef enum logic [1:0] {
        FMT_LEFT     = 2'd0,
        FMT_I2S      = 2'd1,
        FMT_RIGHT    = 2'd2,
        FMT_RIGHT_P1 = 2'd3
    } fmt_t;

    // Field bit that carries the MSB for a given placement.
    function automatic int msb_pos(input fmt_t f, input int field_w, input int sample_w);
        case (f)
            FMT_LEFT:  return 0;
            FMT_I2S:   return 1;
            FMT_RIGHT: return field_w - sample_w;
            default:   return field_w - sample_w + 1;
        endcase
    endfunction

endpackage

// File: rtl/stx_bitclk.sv
// Bit-clock generator. Divides the master clock by DIV_LO or DIV_HI and
// emits a one-cycle launch enable (tick) in the last phase of each bit.
// The bit clock takes its post-launch level on the edge after tick and
// its sampling level at mid period. Assumes DIV_LO and DIV_HI are even
// and at least 2.
module stx_bitclk #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_hi,
    input  logic edge_fall_tx,
    output logic tick,
    output logic bclk
);
    localparam int PH_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] half_ph;

    // Select the terminal and mid-point phases for the active ratio.
    always_comb begin
        last_ph = ratio_hi ? PH_W'(DIV_HI - 1) : PH_W'(DIV_LO - 1);
        half_ph = ratio_hi ? PH_W'(DIV_HI / 2 - 1) : PH_W'(DIV_LO / 2 - 1);
        tick    = (phase >= last_ph);
    end

    // Phase counter; reset lands on the terminal phase so the first frame starts at once.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= last_ph;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    // Bit clock level: post-launch level after tick, sampling level after mid point.
    always_ff @(posedge clk) begin
        if (!rst_n)                bclk <= ~edge_fall_tx;
        else if (tick)             bclk <= ~edge_fall_tx;
        else if (phase == half_ph) bclk <= edge_fall_tx;
    end

endmodule

// File: rtl/stx_slot_ctr.sv
// Frame slot counter. Steps once per bit on the launch enable and exposes
// the slot about to be launched plus a frame-start flag for slot 0.
// Assumes the slot count is a power of two so it wraps naturally.
module stx_slot_ctr #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              frame_start
);
    logic [SLOT_W-1:0] slot;

    // Next slot and frame boundary decode.
    always_comb begin
        slot_nxt    = slot + 1'b1;
        frame_start = tick && (slot_nxt == '0);
    end

    // Slot register; resets to the last slot so slot 0 follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '1;
        else if (tick) slot <= slot_nxt;
    end

endmodule

// File: rtl/stx_shifter.sv
// Sample holding and field serializer. Holds the latest strobed pair,
// moves it into the in-flight pair at each frame start, and on every
// launch enable registers frame clock, word clock and data for the next
// slot. In the delayed right-justified placement the LSB of each word is
// sent in bit 0 of the following field, taken from the in-flight pair
// before it is replaced.
module stx_shifter
    import stx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FIELD_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic                           frame_start,
    input  logic [$clog2(FIELD_W):0]       slot_nxt,
    input  fmt_t                           fmt,
    input  logic                           smp_ready,
    input  logic [SAMPLE_W-1:0]            smp_left,
    input  logic [SAMPLE_W-1:0]            smp_right,
    output logic                           lrclk,
    output logic                           wclk,
    output logic                           sdata
);
    localparam int POS_W = $clog2(FIELD_W);
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] hold_l, hold_r;
    logic [SAMPLE_W-1:0] act_l, act_r;
    logic [SAMPLE_W-1:0] word_l_n, word_r_n, cur_word;
    logic                field_r;
    logic [POS_W-1:0]    pos;
    int                  msb_at;
    int                  rel;
    logic                in_win;
    logic [IDX_W-1:0]    sel;
    logic                bit_n, wclk_n;

    // Decode the upcoming slot into field, position and data bit.
    always_comb begin
        field_r  = slot_nxt[POS_W];
        pos      = slot_nxt[POS_W-1:0];
        word_l_n = frame_start ? hold_l : act_l;
        word_r_n = frame_start ? hold_r : act_r;
        cur_word = field_r ? word_r_n : word_l_n;
        msb_at   = msb_pos(fmt, FIELD_W, SAMPLE_W);
        rel      = int'(pos) - msb_at;
        in_win   = (rel >= 0) && (rel < SAMPLE_W);
        sel      = IDX_W'(SAMPLE_W - 1 - rel);
        if (fmt == FMT_RIGHT_P1 && pos == '0)
            bit_n = field_r ? act_l[0] : act_r[0];
        else
            bit_n = in_win ? cur_word[sel] : 1'b0;
        if (fmt == FMT_RIGHT_P1)
            wclk_n = (int'(pos) == msb_at - 1);
        else
            wclk_n = in_win;
    end

    // Holding pair: captured on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (smp_ready) begin
            hold_l <= smp_left;
            hold_r <= smp_right;
        end
    end

    // In-flight pair: replaced only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (frame_start) begin
            act_l <= hold_l;
            act_r <= hold_r;
        end
    end

    // Output registers: updated on each launch enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrclk <= 1'b0;
            wclk  <= 1'b0;
            sdata <= 1'b0;
        end else if (tick) begin
            lrclk <= ~field_r;
            wclk  <= wclk_n;
            sdata <= bit_n;
        end
    end

endmodule

// File: rtl/stereo_ser_tx.sv
// Top of the master-mode stereo serial transmitter. Ties the bit-clock
// divider, slot counter and serializer together. All logic is in the
// master clock domain; the bit clock is a registered output, never a clock.
module stereo_ser_tx
    import stx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FIELD_W  = 32,
    parameter int DIV_LO   = 4,
    parameter int DIV_HI   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ratio_384,
    input  logic                fmt_right,
    input  logic                fmt_delay,
    input  logic                edge_fall_tx,
    input  logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                wclk_o,
    output logic                sdata_o
);
    localparam int SLOT_W = $clog2(FIELD_W) + 1;

    logic              tick;
    logic              frame_start;
    logic [SLOT_W-1:0] slot_nxt;
    fmt_t              fmt;

    // Placement code from the two select pins.
    always_comb fmt = fmt_t'({fmt_right, fmt_delay});

    stx_bitclk #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) bitclk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_hi     (ratio_384),
        .edge_fall_tx (edge_fall_tx),
        .tick         (tick),
        .bclk         (bclk_o)
    );

    stx_slot_ctr #(.SLOT_W(SLOT_W)) slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .slot_nxt    (slot_nxt),
        .frame_start (frame_start)
    );

    stx_shifter #(.SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .frame_start (frame_start),
        .slot_nxt    (slot_nxt),
        .fmt         (fmt),
        .smp_ready   (smp_ready),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .lrclk       (lrclk_o),
        .wclk        (wclk_o),
        .sdata       (sdata_o)
    );

endmodule

// File: rtl/stx_checker.sv
// Port-level properties of the stereo serial transmitter, bound to the top.
// Assumes the select pins change only while reset is held.
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic fmt_right,
    input logic fmt_delay,
    input logic edge_fall_tx,
    input logic bclk_o,
    input logic lrclk_o,
    input logic wclk_o,
    input logic sdata_o
);
    // R3: frame clock moves only together with a launch edge.
    assert_lr_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_o) |-> (bclk_o != edge_fall_tx));

    // R2: data moves only on the launch edge.
    assert_data_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> (bclk_o != edge_fall_tx));

    // R2: word clock moves only on the launch edge.
    assert_word_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wclk_o) |-> (bclk_o != edge_fall_tx));

    // R8: outside the spill placement, a one on data lies inside the word window.
    assert_zero_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (({fmt_right, fmt_delay} != 2'b11) && sdata_o) |-> wclk_o);

    // R7: in the spill placement the word clock never covers a frame-clock change.
    assert_pulse_no_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (({fmt_right, fmt_delay} == 2'b11) && !$stable(lrclk_o)) |-> !wclk_o);
endmodule

bind stereo_ser_tx stx_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_right    (fmt_right),
    .fmt_delay    (fmt_delay),
    .edge_fall_tx (edge_fall_tx),
    .bclk_o       (bclk_o),
    .lrclk_o      (lrclk_o),
    .wclk_o       (wclk_o),
    .sdata_o      (sdata_o)
);

// File: tb/stereo_ser_tx_tb_top.sv
module stereo_ser_tx_tb_top;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_384 = 1'b0, fmt_right = 1'b0, fmt_delay = 1'b0, edge_fall_tx = 1'b0;
    logic        smp_ready = 1'b0;
    logic [15:0] smp_left = '0, smp_right = '0;
    logic        bclk_o, lrclk_o, wclk_o, sdata_o;

    int n_chk = 0, n_fail = 0, wd = 0, rst_cnt = 0;
    logic [15:0] tb_hold_l = '0, tb_hold_r = '0;

    always #10 clk = ~clk;

    stereo_ser_tx dut_i (
        .clk(clk), .rst_n(rst_n), .ratio_384(ratio_384), .fmt_right(fmt_right),
        .fmt_delay(fmt_delay), .edge_fall_tx(edge_fall_tx), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right), .bclk_o(bclk_o),
        .lrclk_o(lrclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
    );

    // Field model: MSB position per placement code.
    function automatic int e_msb(input int f);
        case (f)
            0: return 0;
            1: return 1;
            2: return 16;
            default: return 17;
        endcase
    endfunction

    function automatic logic e_bit(input int f, input int fld, input int p,
                                   input logic [15:0] wl, input logic [15:0] wr, input logic spl);
        logic [15:0] w;
        int m;
        w = (fld == 0) ? wl : wr;
        m = e_msb(f);
        if (f == 3 && p == 0) return (fld == 0) ? spl : wl[0];
        if (p >= m && p < m + 16) return w[15 - (p - m)];
        return 1'b0;
    endfunction

    function automatic logic e_wclk(input int f, input int p);
        if (f == 3) return (p == 16);
        return (p >= e_msb(f) && p < e_msb(f) + 16);
    endfunction

    function automatic string f_tag(input int f);
        case (f)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor state
    logic        prev_bclk = 1'b0, prev_sd = 1'b0, last_lr = 1'b0, started = 1'b0, seen = 1'b0;
    logic        spill = 1'b0;
    logic [15:0] exp_l = '0, exp_r = '0;
    int          pos = 0, cyc = 0;

    // Monitor: samples away from the active edge and checks every sampled bit.
    always @(negedge clk) begin
        int f, fld;
        logic eb;
        wd++;
        if (wd > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        f = {fmt_right, fmt_delay};
        if (!rst_n) begin
            rst_cnt++;
            if (rst_cnt >= 2) begin
                chk(!lrclk_o && !wclk_o && !sdata_o, "R10 outputs low",
                    {lrclk_o, wclk_o, sdata_o}, 0);
                chk(bclk_o == ~edge_fall_tx, "R10 bclk idle", bclk_o, ~edge_fall_tx);
            end
            prev_bclk = bclk_o; prev_sd = 1'b0; last_lr = 1'b0; started = 1'b0;
            seen = 1'b0; pos = 0; cyc = 0; exp_l = '0; exp_r = '0; spill = 1'b0;
        end else begin
            rst_cnt = 0;
            cyc++;
            if (sdata_o != prev_sd)
                chk(bclk_o != edge_fall_tx, "R2 data launch edge", bclk_o, ~edge_fall_tx);
            if (bclk_o != prev_bclk && bclk_o == edge_fall_tx) begin
                if (seen) chk(cyc == (ratio_384 ? 6 : 4), "R1 bclk period", cyc, ratio_384 ? 6 : 4);
                seen = 1'b1;
                cyc = 0;
                if (lrclk_o != last_lr) begin
                    if (started) chk(pos == 31, "R3 field length", pos + 1, 32);
                    if (lrclk_o) begin
                        spill = exp_r[0];
                        exp_l = tb_hold_l;   // R9: pair held at frame start
                        exp_r = tb_hold_r;
                    end
                    started = 1'b1;
                    pos = 0;
                    last_lr = lrclk_o;
                end else begin
                    pos++;
                end
                fld = lrclk_o ? 0 : 1;
                eb = e_bit(f, fld, pos, exp_l, exp_r, spill);
                chk(sdata_o == eb, (eb == 1'b0 && !e_wclk(f, pos) && !(f == 3 && pos == 0)) ?
                    "R8 unused zero" : {f_tag(f), " data R9"}, sdata_o, eb);
                chk(wclk_o == e_wclk(f, pos), {f_tag(f), " word clock"}, wclk_o, e_wclk(f, pos));
            end
            prev_bclk = bclk_o;
            prev_sd = sdata_o;
        end
    end

    task automatic pulse(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        smp_ready = 1'b1; smp_left = l; smp_right = r;
        tb_hold_l = l; tb_hold_r = r;
        @(negedge clk);
        smp_ready = 1'b0;
    endtask

    task automatic wait_lr(input logic lvl);
        do @(negedge clk); while (lrclk_o != lvl);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int cfg = 0; cfg < 16; cfg++) begin
            @(negedge clk);
            rst_n = 1'b0;
            ratio_384 = cfg[0]; edge_fall_tx = cfg[1];
            fmt_right = cfg[3]; fmt_delay = cfg[2];
            tb_hold_l = '0; tb_hold_r = '0;
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            for (int fr = 0; fr < 5; fr++) begin
                wait_lr(1'b1);
                wait_lr(1'b0);
                case (fr)
                    0: pulse(16'h8000, 16'h7FFF);
                    1: pulse(16'h0001, 16'hFFFE);
                    3: begin
                        pulse(16'($urandom), 16'($urandom));
                        pulse(16'($urandom) | 16'h1, 16'($urandom) | 16'h1); // R9 last write wins
                    end
                    default: pulse(16'($urandom), 16'($urandom));
                endcase
            end
            wait_lr(1'b1);
            wait_lr(1'b0);
            wait_lr(1'b1);
            repeat (20) @(negedge clk);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule